// File: doc/BRIEF.md
# Parallel IO Bank with Peripheral Mux

This block controls a bank of 32 pins from a simple register bus. Each pin is owned either by the general purpose IO logic or by one of two internal peripheral functions, called A and B. When the IO logic owns a pin, software sets its direction and output level. When a peripheral owns it, the output value and output enable come from that peripheral. Every pin has a pull-up enable and an open-drain enable. Each input can be passed through a glitch filter.

Every per-pin attribute has two write-only registers: one that sets bits and one that clears them. A third register reads the attribute back. Only the 1 bits of a written mask act, so software never needs a read-modify-write.

Inputs pass through a synchronizer and then the optional filter. Any change of the filtered level, rising or falling, sets a change flag for that pin. The change flags are cleared by reading them. An interrupt mask selects which flags raise the bank's single interrupt request.

Top module: `pio_bank`

## Requirements
- R1: After reset every pin is owned by the IO logic, pull-ups are on, outputs, open-drain and filters are off, all interrupts are masked, and `irq_o` is low. The synchronized level resets to all ones.
- R2: For ownership (0/1/2), direction (3/4/5), filter (6/7/8), interrupt mask (13/14/15), pull-up (17/18/19) and open-drain (20/21/22), writing the set or clear word (first and second address) changes exactly the pins whose mask bit is 1. The status word (third address) reads the current value, with bit n for pin n. Read data appears on `bus_rdata_o` the cycle after the read strobe.
- R3: Output data is set by writing address 9 and cleared by writing address 10, with a mask. Address 11 reads it back.
- R4: For a pin owned by the IO logic with open-drain off, `pad_oe_o` equals its direction bit and `pad_out_o` equals its output data bit.
- R5: For a pin not owned by the IO logic, writing address 23 selects peripheral A and writing address 24 selects peripheral B. That peripheral's out and oe then drive the pad. Address 25 reads 1 for B, and reset selects A.
- R6: With open-drain on, `pad_out_o` is 0 and the pad is enabled only while the selected drive value is 0.
- R7: Address 12 returns the synchronized, filtered level of every pin, whoever owns it.
- R8: A rising or a falling change of the filtered level sets that pin's change flag, whatever its mask bit.
- R9: Reading address 16 returns the change flags and clears them. A change that lands in the same cycle as the read stays set for the next read.
- R10: `irq_o` is high exactly while some change flag and its mask bit are both 1.
- R11: With the filter on, a level must be seen on two consecutive samples before it is accepted, so a one-cycle pulse raises no flag. With the filter off, the same pulse is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | 5 | Register word address |
| bus_wdata_i | input | 32 | Write data / pin mask |
| bus_rdata_o | output | 32 | Read data, one cycle after the strobe |
| pad_in_i | input | 32 | Pad input levels |
| pad_out_o | output | 32 | Pad drive values |
| pad_oe_o | output | 32 | Pad output enables |
| pad_pullup_o | output | 32 | Pad pull-up enables |
| pa_out_i | input | 32 | Peripheral A drive values |
| pa_oe_i | input | 32 | Peripheral A output enables |
| pb_out_i | input | 32 | Peripheral B drive values |
| pb_oe_i | input | 32 | Peripheral B output enables |
| irq_o | output | 1 | Combined bank interrupt request |

## Verification
The bench builds the bank with its default parameters: 32 pins and a two-stage synchronizer. With these values the top bit 31 is exercised in the set/clear tests. The input-to-flag delay is also fixed, which lets the bench place a status read in exactly the cycle in which a new change lands. A one-cycle pulse can likewise be shown to be rejected by the filter and flagged without it.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;
  localparam int REG_AW = 5;

  typedef enum logic [REG_AW-1:0] {
    A_OWN_SET = 5'd0,  A_OWN_CLR = 5'd1,  A_OWN_ST = 5'd2,
    A_DIR_SET = 5'd3,  A_DIR_CLR = 5'd4,  A_DIR_ST = 5'd5,
    A_FLT_SET = 5'd6,  A_FLT_CLR = 5'd7,  A_FLT_ST = 5'd8,
    A_DAT_SET = 5'd9,  A_DAT_CLR = 5'd10, A_DAT_ST = 5'd11,
    A_LEVEL   = 5'd12,
    A_IEN_SET = 5'd13, A_IEN_CLR = 5'd14, A_IEN_ST = 5'd15,
    A_CHG_ST  = 5'd16,
    A_PU_SET  = 5'd17, A_PU_CLR  = 5'd18, A_PU_ST  = 5'd19,
    A_OD_SET  = 5'd20, A_OD_CLR  = 5'd21, A_OD_ST  = 5'd22,
    A_SEL_A   = 5'd23, A_SEL_B   = 5'd24, A_SEL_ST = 5'd25
  } reg_addr_e;
endpackage

// File: rtl/pio_inputs.sv
`timescale 1ns/1ps
module pio_inputs #(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pad_i,
  input  logic [NPINS-1:0] flt_en_i,
  output logic [NPINS-1:0] level_o,
  output logic [NPINS-1:0] change_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NPINS-1:0] sync_q [SYNC_STAGES];
  logic [NPINS-1:0] samp, samp_prev_q, level_q, level_prev_q, accept;

  assign samp = sync_q[LAST];

  // filter accepts a sample only when it matches the previous one
  for (genvar i = 0; i < NPINS; i++) begin : g_flt
    assign accept[i] = ~flt_en_i[i] | (samp[i] == samp_prev_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '1;
      samp_prev_q  <= '1;
      level_q      <= '1;
      level_prev_q <= '1;
    end else begin
      sync_q[0] <= pad_i;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      samp_prev_q  <= samp;
      level_q      <= (level_q & ~accept) | (samp & accept);
      level_prev_q <= level_q;
    end
  end

  assign level_o  = level_q;
  assign change_o = level_q ^ level_prev_q;

  // R11
  flt_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((level_q ^ $past(level_q)) & $past(flt_en_i) &
     ($past(samp) ^ $past(samp_prev_q))) == '0);
endmodule

// File: rtl/pio_regs.sv
`timescale 1ns/1ps
module pio_regs
  import pio_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [NPINS-1:0]  bus_wdata_i,
  output logic [NPINS-1:0]  bus_rdata_o,
  input  logic [NPINS-1:0]  level_i,
  input  logic [NPINS-1:0]  change_i,
  output logic [NPINS-1:0]  own_o,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  flt_o,
  output logic [NPINS-1:0]  dat_o,
  output logic [NPINS-1:0]  pu_o,
  output logic [NPINS-1:0]  od_o,
  output logic [NPINS-1:0]  bsel_o,
  output logic              irq_o
);
  logic [NPINS-1:0] own_q, dir_q, flt_q, dat_q, pu_q, od_q, bsel_q, ien_q, stat_q;
  logic [NPINS-1:0] rd_mux, rdata_q;
  logic             stat_rd;

  assign stat_rd = bus_re_i && (bus_addr_i == A_CHG_ST);

  always_comb begin
    case (bus_addr_i)
      A_OWN_ST: rd_mux = own_q;
      A_DIR_ST: rd_mux = dir_q;
      A_FLT_ST: rd_mux = flt_q;
      A_DAT_ST: rd_mux = dat_q;
      A_LEVEL:  rd_mux = level_i;
      A_IEN_ST: rd_mux = ien_q;
      A_CHG_ST: rd_mux = stat_q;
      A_PU_ST:  rd_mux = pu_q;
      A_OD_ST:  rd_mux = od_q;
      A_SEL_ST: rd_mux = bsel_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q   <= '1;
      dir_q   <= '0;
      flt_q   <= '0;
      dat_q   <= '0;
      pu_q    <= '1;
      od_q    <= '0;
      bsel_q  <= '0;
      ien_q   <= '0;
      stat_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (bus_we_i) begin
        case (bus_addr_i)
          A_OWN_SET: own_q  <= own_q  |  bus_wdata_i;
          A_OWN_CLR: own_q  <= own_q  & ~bus_wdata_i;
          A_DIR_SET: dir_q  <= dir_q  |  bus_wdata_i;
          A_DIR_CLR: dir_q  <= dir_q  & ~bus_wdata_i;
          A_FLT_SET: flt_q  <= flt_q  |  bus_wdata_i;
          A_FLT_CLR: flt_q  <= flt_q  & ~bus_wdata_i;
          A_DAT_SET: dat_q  <= dat_q  |  bus_wdata_i;
          A_DAT_CLR: dat_q  <= dat_q  & ~bus_wdata_i;
          A_IEN_SET: ien_q  <= ien_q  |  bus_wdata_i;
          A_IEN_CLR: ien_q  <= ien_q  & ~bus_wdata_i;
          A_PU_SET:  pu_q   <= pu_q   |  bus_wdata_i;
          A_PU_CLR:  pu_q   <= pu_q   & ~bus_wdata_i;
          A_OD_SET:  od_q   <= od_q   |  bus_wdata_i;
          A_OD_CLR:  od_q   <= od_q   & ~bus_wdata_i;
          A_SEL_A:   bsel_q <= bsel_q & ~bus_wdata_i;
          A_SEL_B:   bsel_q <= bsel_q |  bus_wdata_i;
          default: ;
        endcase
      end
      // a change landing with the read survives it
      stat_q <= stat_rd ? change_i : (stat_q | change_i);
      if (bus_re_i) rdata_q <= rd_mux;
    end
  end

  assign own_o       = own_q;
  assign dir_o       = dir_q;
  assign flt_o       = flt_q;
  assign dat_o       = dat_q;
  assign pu_o        = pu_q;
  assign od_o        = od_q;
  assign bsel_o      = bsel_q;
  assign bus_rdata_o = rdata_q;
  assign irq_o       = |(stat_q & ien_q);

  // R2
  own_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && bus_addr_i == A_OWN_SET |=>
      (own_q & $past(bus_wdata_i)) == $past(bus_wdata_i));
  // R2
  dir_clr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && bus_addr_i == A_DIR_CLR |=>
      (dir_q & $past(bus_wdata_i)) == '0 &&
      (dir_q & ~$past(bus_wdata_i)) == ($past(dir_q) & ~$past(bus_wdata_i)));
  // R3
  dat_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && bus_addr_i == A_DAT_SET |=>
      (dat_q & $past(bus_wdata_i)) == $past(bus_wdata_i));
  // R8
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|change_i) |=> (stat_q & $past(change_i)) == $past(change_i));
  // R9
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_re_i && bus_addr_i == A_CHG_ST && change_i == '0 |=> stat_q == '0);
  // R10
  mask_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && bus_addr_i == A_IEN_CLR && bus_wdata_i == '1 |=> !irq_o);
endmodule

// File: rtl/pio_pad_mux.sv
`timescale 1ns/1ps
module pio_pad_mux #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] own_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic [NPINS-1:0] dat_i,
  input  logic [NPINS-1:0] od_i,
  input  logic [NPINS-1:0] bsel_i,
  input  logic [NPINS-1:0] pa_out_i,
  input  logic [NPINS-1:0] pa_oe_i,
  input  logic [NPINS-1:0] pb_out_i,
  input  logic [NPINS-1:0] pb_oe_i,
  output logic [NPINS-1:0] pad_out_o,
  output logic [NPINS-1:0] pad_oe_o
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic drv, en;
    assign drv = own_i[i] ? dat_i[i] : (bsel_i[i] ? pb_out_i[i] : pa_out_i[i]);
    assign en  = own_i[i] ? dir_i[i] : (bsel_i[i] ? pb_oe_i[i]  : pa_oe_i[i]);
    // open drain: only ever pulls low
    assign pad_oe_o[i]  = en & ~(od_i[i] & drv);
    assign pad_out_o[i] = drv & ~od_i[i];
  end
endmodule

// File: rtl/pio_bank.sv
`timescale 1ns/1ps
module pio_bank
  import pio_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [NPINS-1:0]  bus_wdata_i,
  output logic [NPINS-1:0]  bus_rdata_o,
  input  logic [NPINS-1:0]  pad_in_i,
  output logic [NPINS-1:0]  pad_out_o,
  output logic [NPINS-1:0]  pad_oe_o,
  output logic [NPINS-1:0]  pad_pullup_o,
  input  logic [NPINS-1:0]  pa_out_i,
  input  logic [NPINS-1:0]  pa_oe_i,
  input  logic [NPINS-1:0]  pb_out_i,
  input  logic [NPINS-1:0]  pb_oe_i,
  output logic              irq_o
);
  logic [NPINS-1:0] level, change, own, dir, flt, dat, od, bsel;

  pio_inputs #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_in (
    .clk_i, .rst_ni, .pad_i(pad_in_i), .flt_en_i(flt),
    .level_o(level), .change_o(change)
  );

  pio_regs #(.NPINS(NPINS)) u_regs (
    .clk_i, .rst_ni, .bus_we_i, .bus_re_i, .bus_addr_i, .bus_wdata_i,
    .bus_rdata_o, .level_i(level), .change_i(change),
    .own_o(own), .dir_o(dir), .flt_o(flt), .dat_o(dat), .pu_o(pad_pullup_o),
    .od_o(od), .bsel_o(bsel), .irq_o
  );

  pio_pad_mux #(.NPINS(NPINS)) u_mux (
    .own_i(own), .dir_i(dir), .dat_i(dat), .od_i(od), .bsel_i(bsel),
    .pa_out_i, .pa_oe_i, .pb_out_i, .pb_oe_i, .pad_out_o, .pad_oe_o
  );

  // R4
  gpio_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o ^ dir) & own & ~od) == '0);
endmodule

// File: tb/sim_pio_bank.sv
`timescale 1ns/1ps
module sim_pio_bank;
  import pio_pkg::*;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] pad_in = '1, pad_out, pad_oe, pad_pu;
  logic [31:0] pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pio_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .pad_pullup_o(pad_pu), .pa_out_i(pa_out), .pa_oe_i(pa_oe),
    .pb_out_i(pb_out), .pb_oe_i(pb_oe), .irq_o(irq)
  );

  typedef struct packed {
    logic [4:0]  wa;
    logic [31:0] wd;
    logic [4:0]  ra;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{A_DIR_SET, 32'h0000_00FF, A_DIR_ST, 32'h0000_00FF}, // R2
    '{A_DIR_CLR, 32'h0000_000F, A_DIR_ST, 32'h0000_00F0}, // R2
    '{A_DIR_CLR, 32'h0000_0000, A_DIR_ST, 32'h0000_00F0}, // R2 zero mask
    '{A_DAT_SET, 32'hA5A5_0000, A_DAT_ST, 32'hA5A5_0000}, // R3
    '{A_DAT_CLR, 32'h8000_0000, A_DAT_ST, 32'h25A5_0000}, // R3
    '{A_OWN_CLR, 32'h0000_FF00, A_OWN_ST, 32'hFFFF_00FF}, // R2
    '{A_SEL_B,   32'h0000_0F00, A_SEL_ST, 32'h0000_0F00}, // R5
    '{A_SEL_A,   32'h0000_0300, A_SEL_ST, 32'h0000_0C00}, // R5
    '{A_PU_CLR,  32'hFFFF_0000, A_PU_ST,  32'h0000_FFFF}, // R2
    '{A_OD_SET,  32'h0000_0030, A_OD_ST,  32'h0000_0030}, // R2
    '{A_FLT_SET, 32'h8000_0001, A_FLT_ST, 32'h8000_0001}, // R2
    '{A_FLT_CLR, 32'h8000_0001, A_FLT_ST, 32'h0000_0000}, // R2
    '{A_IEN_SET, 32'h0000_0003, A_IEN_ST, 32'h0000_0003}, // R2
    '{A_IEN_CLR, 32'h0000_0003, A_IEN_ST, 32'h0000_0000}  // R2
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 pad_oe", pad_oe, 32'd0);
    chk("R1 pullup", pad_pu, '1);
    rd(A_OWN_ST, v); chk("R1 own", v, '1);
    rd(A_DIR_ST, v); chk("R1 dir", v, 32'd0);
    rd(A_IEN_ST, v); chk("R1 mask", v, 32'd0);
    rd(A_FLT_ST, v); chk("R1 filter", v, 32'd0);
    rd(A_SEL_ST, v); chk("R5 reset sel A", v, 32'd0);
    rd(A_CHG_ST, v); chk("R1 flags", v, 32'd0);

    foreach (VECS[i]) begin
      wr(VECS[i].wa, VECS[i].wd);
      rd(VECS[i].ra, v);
      chk($sformatf("R2/R3/R5 vec%0d", i), v, VECS[i].exp);
    end
    chk("R2 pullup pins", pad_pu, 32'h0000_FFFF);

    // R4 / R6: dir=F0, dat low byte 0, od=30
    chk("R6 od drive0 oe", pad_oe & 32'hFF, 32'h0000_00F0);
    chk("R6 od out low", pad_out & 32'h30, 32'd0);
    wr(A_DAT_SET, 32'h0000_0050);
    chk("R6 od release", pad_oe & 32'hFF, 32'h0000_00E0);
    chk("R4 gpio out", pad_out & 32'hFF, 32'h0000_0040);

    // R5 peripheral mux on pins 8..15, B on 10,11
    pa_out = 32'h0000_FF00; pa_oe = 32'h0000_0100;
    pb_out = 32'h0000_0000; pb_oe = 32'h0000_0C00;
    @(negedge clk);
    chk("R5 periph oe", pad_oe & 32'hFF00, 32'h0000_0D00);
    chk("R5 periph out", pad_out & 32'hFF00, 32'h0000_F300);

    // R7 / R8 level and both edges on a peripheral pin
    pad_in[9] = 1'b0; settle();
    rd(A_LEVEL, v); chk("R7 level", v, 32'hFFFF_FDFF);
    rd(A_CHG_ST, v); chk("R8 fall flag", v, 32'h0000_0200);
    rd(A_CHG_ST, v); chk("R9 cleared", v, 32'd0);
    pad_in[9] = 1'b1; settle();
    rd(A_CHG_ST, v); chk("R8 rise flag", v, 32'h0000_0200);
    chk("R10 masked no irq", {31'd0, irq}, 32'd0);

    // R10 mask
    wr(A_IEN_SET, 32'h0000_0001);
    pad_in[1] = 1'b0; settle();
    chk("R10 masked pin no irq", {31'd0, irq}, 32'd0);
    pad_in[0] = 1'b0; settle();
    chk("R10 irq high", {31'd0, irq}, 32'd1);
    rd(A_CHG_ST, v); chk("R8 flags", v, 32'h0000_0003);
    chk("R10 irq low after read", {31'd0, irq}, 32'd0);

    // R9 change landing with the read
    @(negedge clk); pad_in[3] = 1'b0;
    repeat (3) @(negedge clk);
    re = 1'b1; addr = A_CHG_ST;
    @(negedge clk); re = 1'b0; v = rdata;
    chk("R9 same-cycle read", v, 32'd0);
    rd(A_CHG_ST, v); chk("R9 kept", v, 32'h0000_0008);

    // R11 filter
    wr(A_FLT_SET, 32'h0000_0004);
    @(negedge clk); pad_in[2] = 1'b0;
    @(negedge clk); pad_in[2] = 1'b1;
    settle();
    rd(A_CHG_ST, v); chk("R11 pulse rejected", v, 32'd0);
    pad_in[2] = 1'b0; settle();
    rd(A_CHG_ST, v); chk("R11 long level accepted", v, 32'h0000_0004);
    pad_in[2] = 1'b1; settle();
    rd(A_CHG_ST, v);
    wr(A_FLT_CLR, 32'h0000_0004);
    @(negedge clk); pad_in[2] = 1'b0;
    @(negedge clk); pad_in[2] = 1'b1;
    settle();
    rd(A_CHG_ST, v); chk("R11 pulse flagged unfiltered", v, 32'h0000_0004);

    finish_run();
  end
endmodule